// File: doc/BRIEF.md
# Set/Clear Control Register File

This block is the control and status register file of a host-controller style device. It decodes a 2 KB window behind a plain 32-bit bus (address, write strobe, write data, read strobe, read data). Several control registers are given two write addresses. Writing to the "set" address turns on the bits written as one. Writing to the "clear" address turns off the bits written as one. Software can therefore change single bits without a read-modify-write sequence, so it cannot race with hardware or with other software agents.

There are three set/clear registers: a host-control register, an interrupt event register and an interrupt mask register. Hardware event lines feed the event register. A read of the event register through its clear address returns only the events that the mask enables. An interrupt line stays high while any enabled event is pending. A read-only version word and a transmit retry register, which is read/write in its low half, complete the map. Read data is registered and appears one cycle after the read strobe.

Top module: `ctl_regfile_sc`

## Requirements
- R1: A synchronous active-high reset sets the host-control, event, mask and retry registers, the read data and the interrupt line to zero.
- R2: A write to a set address (host control 050h, event 080h, mask 088h) sets every register bit whose data bit is 1. All other bits keep their value.
- R3: A write to a clear address (host control 054h, event 084h, mask 08Ch) clears every register bit whose data bit is 1. All other bits keep their value.
- R4: A read from either address of the host-control or mask pair returns the full register contents.
- R5: A read of the event set address 080h returns the raw event bits. A read of the event clear address 084h returns the event bits ANDed with the mask.
- R6: On every cycle, each hardware event input that is 1 sets its event bit. When the same bit is also cleared by software in that cycle, the bit ends up set.
- R7: The interrupt output is 1 exactly when (event AND mask) is non-zero. It follows each register update in the same cycle as that update.
- R8: Offset 000h reads the constant VERSION_VAL. Writes to 000h change nothing.
- R9: Offset 008h is the retry register. A write replaces the bits selected by RETRY_WMASK (default 0000FFFFh). All other bits read as zero.
- R10: Only address bits [10:2] select a register. Bits [1:0] and all bits above bit 10 are ignored, so addresses that differ only in those bits alias.
- R11: Reads of any unmapped offset return zero. Writes to an unmapped offset change no register.
- R12: Read data is registered. bus_rdata holds the addressed value in the cycle after bus_rd is 1, and holds zero in the cycle after bus_rd is 0. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (32) | Byte address; bits [10:2] decoded |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| hw_event | input | 32 | Hardware event lines, one per event bit |
| irq_out | output | 1 | High while any enabled event is pending |

## Verification
The assertions assume that every input is defined (no X or Z) at each rising edge and that reset is held high through the first edge. They make no assumption about the order of accesses. A read and a write may share a cycle, and hardware events may arrive on any cycle, including one that carries a software clear of the same bit. The stimulus changes inputs only on falling edges and starts in reset. It mixes directed sequences with a pseudo-random stream that hits every mapped offset, aliased addresses and unmapped offsets. All of this stays within those assumptions and still reaches the set/clear collision case.

// File: rtl/ctl_regfile_pkg.sv
package ctl_regfile_pkg;

  localparam int DATA_W = 32;
  localparam int WIN_W  = 11;
  localparam int IDX_W  = WIN_W - 2;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  widx_t;

  // word indices (byte offset >> 2)
  localparam widx_t IDX_VERSION  = widx_t'(9'h000);
  localparam widx_t IDX_RETRY    = widx_t'(9'h002);
  localparam widx_t IDX_HCTL_SET = widx_t'(9'h014);
  localparam widx_t IDX_HCTL_CLR = widx_t'(9'h015);
  localparam widx_t IDX_EVT_SET  = widx_t'(9'h020);
  localparam widx_t IDX_EVT_CLR  = widx_t'(9'h021);
  localparam widx_t IDX_MSK_SET  = widx_t'(9'h022);
  localparam widx_t IDX_MSK_CLR  = widx_t'(9'h023);

  // set/clear register slots
  localparam int NUM_SC  = 3;
  localparam int SC_HCTL = 0;
  localparam int SC_EVT  = 1;
  localparam int SC_MSK  = 2;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_VERSION,
    SEL_RETRY,
    SEL_HCTL_SET,
    SEL_HCTL_CLR,
    SEL_EVT_SET,
    SEL_EVT_CLR,
    SEL_MSK_SET,
    SEL_MSK_CLR
  } rsel_e;

  typedef struct packed {
    logic [NUM_SC-1:0] set_we;
    logic [NUM_SC-1:0] clr_we;
    logic              retry_we;
  } wstrobe_t;

  function automatic rsel_e decode_idx(input widx_t idx);
    rsel_e s;
    case (idx)
      IDX_VERSION:  s = SEL_VERSION;
      IDX_RETRY:    s = SEL_RETRY;
      IDX_HCTL_SET: s = SEL_HCTL_SET;
      IDX_HCTL_CLR: s = SEL_HCTL_CLR;
      IDX_EVT_SET:  s = SEL_EVT_SET;
      IDX_EVT_CLR:  s = SEL_EVT_CLR;
      IDX_MSK_SET:  s = SEL_MSK_SET;
      IDX_MSK_CLR:  s = SEL_MSK_CLR;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic is_mapped(input widx_t idx);
    return decode_idx(idx) != SEL_NONE;
  endfunction

  // Software set/clear, then hardware set last so it wins a collision.
  function automatic word_t sc_next(input word_t cur, input word_t setm,
                                    input word_t clrm, input word_t hwm);
    return ((cur | setm) & ~clrm) | hwm;
  endfunction

  function automatic word_t masked_view(input word_t evt, input word_t msk);
    return evt & msk;
  endfunction

  function automatic word_t field_write(input word_t cur, input word_t wd,
                                        input word_t wmask);
    return (cur & ~wmask) | (wd & wmask);
  endfunction

endpackage

// File: rtl/ctl_regfile_decode.sv
module ctl_regfile_decode
  import ctl_regfile_pkg::*;
(
  input  widx_t    idx,
  input  logic     wr,
  output rsel_e    sel,
  output wstrobe_t stb
);

  always_comb begin
    sel = decode_idx(idx);
    stb = '0;
    if (wr) begin
      case (sel)
        SEL_RETRY:    stb.retry_we        = 1'b1;
        SEL_HCTL_SET: stb.set_we[SC_HCTL] = 1'b1;
        SEL_HCTL_CLR: stb.clr_we[SC_HCTL] = 1'b1;
        SEL_EVT_SET:  stb.set_we[SC_EVT]  = 1'b1;
        SEL_EVT_CLR:  stb.clr_we[SC_EVT]  = 1'b1;
        SEL_MSK_SET:  stb.set_we[SC_MSK]  = 1'b1;
        SEL_MSK_CLR:  stb.clr_we[SC_MSK]  = 1'b1;
        default:      stb = '0;
      endcase
    end
  end

endmodule

// File: rtl/ctl_regfile_screg.sv
module ctl_regfile_screg
  import ctl_regfile_pkg::*;
#(
  parameter word_t RESET_VAL = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  set_we,
  input  logic  clr_we,
  input  word_t wdata,
  input  word_t hw_set,
  output word_t q
);

  word_t set_mask;
  word_t clr_mask;

  assign set_mask = set_we ? wdata : '0;
  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= sc_next(q, set_mask, clr_mask, hw_set);
  end

endmodule

// File: rtl/ctl_regfile_plainreg.sv
module ctl_regfile_plainreg
  import ctl_regfile_pkg::*;
#(
  parameter word_t WMASK = '1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  word_t wdata,
  output word_t q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= field_write(q, wdata, WMASK);
  end

endmodule

// File: rtl/ctl_regfile_rdmux.sv
module ctl_regfile_rdmux
  import ctl_regfile_pkg::*;
#(
  parameter word_t VERSION_VAL = 32'h0001_0000
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  rd,
  input  rsel_e sel,
  input  word_t retry_q,
  input  word_t hctl_q,
  input  word_t evt_q,
  input  word_t msk_q,
  output word_t rdata
);

  word_t rd_val;

  always_comb begin
    case (sel)
      SEL_VERSION:                rd_val = VERSION_VAL;
      SEL_RETRY:                  rd_val = retry_q;
      SEL_HCTL_SET, SEL_HCTL_CLR: rd_val = hctl_q;
      SEL_EVT_SET:                rd_val = evt_q;
      SEL_EVT_CLR:                rd_val = masked_view(evt_q, msk_q);
      SEL_MSK_SET, SEL_MSK_CLR:   rd_val = msk_q;
      default:                    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
    else         rdata <= '0;
  end

endmodule

// File: rtl/ctl_regfile_sc.sv
module ctl_regfile_sc
  import ctl_regfile_pkg::*;
#(
  parameter int    ADDR_W      = 32,
  parameter word_t VERSION_VAL = 32'h0001_0000,
  parameter word_t RETRY_WMASK = 32'h0000_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] hw_event,
  output logic              irq_out
);

  widx_t    acc_idx;
  rsel_e    acc_sel;
  wstrobe_t acc_stb;
  word_t    sc_q [NUM_SC];
  word_t    hctl_q;
  word_t    evt_q;
  word_t    msk_q;
  word_t    retry_q;
  word_t    evt_hits;
  logic     unused_addr_bits;

  // window decode: word index from bits [10:2]
  assign acc_idx          = bus_addr[WIN_W-1:2];
  assign unused_addr_bits = ^{bus_addr[1:0], bus_addr[ADDR_W-1:WIN_W]};

  ctl_regfile_decode u_decode (
    .idx (acc_idx),
    .wr  (bus_wr),
    .sel (acc_sel),
    .stb (acc_stb)
  );

  for (genvar g = 0; g < NUM_SC; g++) begin : g_sc
    word_t hw_in;
    assign hw_in = (g == SC_EVT) ? hw_event : '0;

    ctl_regfile_screg u_reg (
      .clk    (clk),
      .rst    (rst),
      .set_we (acc_stb.set_we[g]),
      .clr_we (acc_stb.clr_we[g]),
      .wdata  (bus_wdata),
      .hw_set (hw_in),
      .q      (sc_q[g])
    );
  end

  ctl_regfile_plainreg #(.WMASK(RETRY_WMASK)) u_retry (
    .clk   (clk),
    .rst   (rst),
    .we    (acc_stb.retry_we),
    .wdata (bus_wdata),
    .q     (retry_q)
  );

  assign hctl_q = sc_q[SC_HCTL];
  assign evt_q  = sc_q[SC_EVT];
  assign msk_q  = sc_q[SC_MSK];

  ctl_regfile_rdmux #(.VERSION_VAL(VERSION_VAL)) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd      (bus_rd),
    .sel     (acc_sel),
    .retry_q (retry_q),
    .hctl_q  (hctl_q),
    .evt_q   (evt_q),
    .msk_q   (msk_q),
    .rdata   (bus_rdata)
  );

  assign evt_hits = masked_view(evt_q, msk_q);
  assign irq_out  = |evt_hits;

endmodule

// File: rtl/ctl_regfile_chk.sv
module ctl_regfile_chk
  import ctl_regfile_pkg::*;
#(
  parameter int    ADDR_W      = 32,
  parameter word_t VERSION_VAL = 32'h0001_0000
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] hw_event,
  input logic              irq_out,
  input word_t             hctl_q,
  input word_t             evt_q,
  input word_t             msk_q,
  input word_t             retry_q
);

  widx_t c_idx;
  assign c_idx = bus_addr[WIN_W-1:2];

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (hctl_q == '0 && evt_q == '0 && msk_q == '0 &&
             retry_q == '0 && bus_rdata == '0 && !irq_out));

  assert_set_ors_ones_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && c_idx == IDX_HCTL_SET) |=>
      ((hctl_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clear_drops_ones_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && c_idx == IDX_MSK_CLR) |=> ((msk_q & $past(bus_wdata)) == '0));

  assert_masked_read_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && c_idx == IDX_EVT_CLR) |=> ((bus_rdata & ~$past(msk_q)) == '0));

  assert_hw_event_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (hw_event != '0) |=> ((evt_q & $past(hw_event)) == $past(hw_event)));

  assert_irq_needs_both_R7: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (evt_q != '0 && msk_q != '0));

  assert_version_const_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && c_idx == IDX_VERSION) |=> (bus_rdata == VERSION_VAL));

  assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !is_mapped(c_idx)) |=>
      ($stable(hctl_q) && $stable(msk_q) && $stable(retry_q)));

  assert_idle_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

endmodule

bind ctl_regfile_sc ctl_regfile_chk #(
  .ADDR_W      (ADDR_W),
  .VERSION_VAL (VERSION_VAL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .hw_event  (hw_event),
  .irq_out   (irq_out),
  .hctl_q    (hctl_q),
  .evt_q     (evt_q),
  .msk_q     (msk_q),
  .retry_q   (retry_q)
);

// File: tb/test_ctl_regfile_sc.sv
module test_ctl_regfile_sc;

  localparam time         CLK_PERIOD = 10ns;
  localparam logic [31:0] VER        = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] b_addr = '0;
  logic        b_wr = 1'b0;
  logic [31:0] b_wdata = '0;
  logic        b_rd = 1'b0;
  logic [31:0] b_rdata;
  logic [31:0] b_hw = '0;
  logic        b_irq;

  int    checks = 0;
  int    failures = 0;
  bit    armed = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference state
  logic [31:0] m_hctl = '0, m_evt = '0, m_msk = '0, m_retry = '0, m_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_regfile_sc #(.ADDR_W(32), .VERSION_VAL(VER), .RETRY_WMASK(32'h0000_FFFF)) i_ctl_regfile_sc (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (b_addr),
    .bus_wr    (b_wr),
    .bus_wdata (b_wdata),
    .bus_rd    (b_rd),
    .bus_rdata (b_rdata),
    .hw_event  (b_hw),
    .irq_out   (b_irq)
  );

  function automatic logic [31:0] ref_read(input logic [31:0] a);
    int off;
    off = int'(a & 32'h0000_07FC);
    case (off)
      'h000:        return VER;
      'h008:        return m_retry;
      'h050, 'h054: return m_hctl;
      'h080:        return m_evt;
      'h084:        return m_evt & m_msk;
      'h088, 'h08C: return m_msk;
      default:      return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : ref_model
    logic [31:0] nh, ne, nm, nr;
    int off;
    if (rst) begin
      m_hctl <= '0; m_evt <= '0; m_msk <= '0; m_retry <= '0; m_rdata <= '0;
    end else begin
      nh = m_hctl; ne = m_evt; nm = m_msk; nr = m_retry;
      off = int'(b_addr & 32'h0000_07FC);
      if (b_wr) begin
        case (off)
          'h008: nr = b_wdata & 32'h0000_FFFF;
          'h050: nh = nh | b_wdata;
          'h054: nh = nh & ~b_wdata;
          'h080: ne = ne | b_wdata;
          'h084: ne = ne & ~b_wdata;
          'h088: nm = nm | b_wdata;
          'h08C: nm = nm & ~b_wdata;
          default: ;
        endcase
      end
      ne = ne | b_hw;
      m_rdata <= b_rd ? ref_read(b_addr) : 32'h0;
      m_hctl <= nh; m_evt <= ne; m_msk <= nm; m_retry <= nr;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference model (R12 timing, R7 irq)
  always @(negedge clk) begin
    if (armed && !done) begin
      check(b_rdata === m_rdata, {cur_req, " rdata vs model R12"}, b_rdata, m_rdata);
      check(b_irq === (|(m_evt & m_msk)), {cur_req, " irq vs model R7"},
            {31'b0, b_irq}, {31'b0, |(m_evt & m_msk)});
    end
  end

  task automatic drive(input logic wr, input logic rd, input logic [31:0] a,
                       input logic [31:0] d, input logic [31:0] h);
    @(negedge clk);
    b_wr = wr; b_rd = rd; b_addr = a; b_wdata = d; b_hw = h;
  endtask

  task automatic idle_now();
    b_wr = 0; b_rd = 0; b_addr = '0; b_wdata = '0; b_hw = '0;
  endtask

  task automatic wr_reg(input logic [31:0] a, input logic [31:0] d);
    drive(1, 0, a, d, '0);
  endtask

  task automatic expect_read(input logic [31:0] a, input logic [31:0] exp,
                             input string tag);
    drive(0, 1, a, '0, '0);
    @(negedge clk);
    check(b_rdata === exp, tag, b_rdata, exp);
    idle_now();
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    drive(0, 0, '0, '0, '0);
    check(b_irq === exp, tag, {31'b0, b_irq}, {31'b0, exp});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lfsr;
    logic [31:0] addrs [10];
    @(negedge clk);
    armed = 1;
    repeat (2) @(negedge clk);
    // R1: state in reset
    check(b_rdata === 32'h0, "R1 rdata in reset", b_rdata, 32'h0);
    check(b_irq === 1'b0, "R1 irq in reset", {31'b0, b_irq}, 32'h0);
    rst = 0;
    cur_req = "R1";
    expect_read(32'h050, 32'h0, "R1 hctl after reset");
    expect_read(32'h080, 32'h0, "R1 event after reset");
    expect_read(32'h088, 32'h0, "R1 mask after reset");
    expect_read(32'h008, 32'h0, "R1 retry after reset");

    cur_req = "R8";
    expect_read(32'h000, VER, "R8 version read");
    wr_reg(32'h000, 32'hFFFF_FFFF);
    expect_read(32'h000, VER, "R8 version after write");

    cur_req = "R9";
    wr_reg(32'h008, 32'h1234_5678);
    expect_read(32'h008, 32'h0000_5678, "R9 retry masked write");

    cur_req = "R2";
    wr_reg(32'h050, 32'h0000_00F0);
    wr_reg(32'h050, 32'h0000_0003);
    expect_read(32'h050, 32'h0000_00F3, "R2 hctl set accumulates");
    cur_req = "R4";
    expect_read(32'h054, 32'h0000_00F3, "R4 hctl via clear address");
    cur_req = "R3";
    wr_reg(32'h054, 32'h0000_0031);
    expect_read(32'h050, 32'h0000_00C2, "R3 hctl clear ones");

    cur_req = "R5";
    wr_reg(32'h088, 32'h0000_000F);
    expect_read(32'h08C, 32'h0000_000F, "R4 mask via clear address");
    wr_reg(32'h080, 32'h0000_00F0);
    expect_irq(1'b0, "R7 unmasked events give no irq");
    expect_read(32'h080, 32'h0000_00F0, "R5 raw event read");
    expect_read(32'h084, 32'h0000_0000, "R5 masked event read empty");
    wr_reg(32'h080, 32'h0000_0001);
    expect_irq(1'b1, "R7 enabled event raises irq");
    expect_read(32'h084, 32'h0000_0001, "R5 masked event read");

    cur_req = "R6";
    drive(1, 0, 32'h084, 32'h0000_0100, 32'h0000_0100);
    expect_read(32'h080, 32'h0000_01F1, "R6 hw set beats sw clear");
    drive(0, 0, 32'h0, 32'h0, 32'h0000_0200);
    expect_read(32'h080, 32'h0000_03F1, "R6 hw event sets bit");
    wr_reg(32'h084, 32'hFFFF_FFFF);
    expect_irq(1'b0, "R7 irq drops after clear");

    cur_req = "R10";
    wr_reg(32'h0000_0850, 32'h0000_0008);
    expect_read(32'hFFFF_F857, 32'h0000_00CA, "R10 aliased address");

    cur_req = "R11";
    wr_reg(32'h0C0, 32'hFFFF_FFFF);
    expect_read(32'h0C0, 32'h0, "R11 unmapped reads zero");
    expect_read(32'h050, 32'h0000_00CA, "R11 unmapped write ignored");

    cur_req = "R12";
    drive(0, 0, 32'h050, 32'h0, 32'h0);
    @(negedge clk);
    check(b_rdata === 32'h0, "R12 no read gives zero", b_rdata, 32'h0);
    idle_now();
    drive(1, 1, 32'h050, 32'h0000_0001, 32'h0);
    @(negedge clk);
    check(b_rdata === 32'h0000_00CA, "R12 read before same-cycle write", b_rdata, 32'h0000_00CA);
    idle_now();

    cur_req = "R1";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    expect_read(32'h050, 32'h0, "R1 hctl after mid-run reset");
    expect_read(32'h008, 32'h0, "R1 retry after mid-run reset");

    // mixed pseudo-random traffic compared against the model every clock
    cur_req = "R2/R3/R5/R6 mix";
    addrs = '{32'h000, 32'h008, 32'h050, 32'h054, 32'h080,
              32'h084, 32'h088, 32'h08C, 32'h0C4, 32'h3F0};
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, d, h;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = addrs[lfsr[3:0] % 10] | (lfsr[31:29] == 3'b111 ? 32'hFFFF_F800 : 32'h0);
      d = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      h = (lfsr[8:6] == 3'b000) ? (32'h1 << lfsr[13:9]) : 32'h0;
      drive(lfsr[4], lfsr[5], a, d, h);
    end
    drive(0, 0, '0, '0, '0);
    @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule